// File: doc/BRIEF.md
# Coin-Accumulating Release Controller

This synchronous controller counts credit from two coin inputs and opens a release chute once a fixed price of 15 cents has been paid. One input reports a 5-cent coin and the other a 10-cent coin. Each coin appears as a pulse that lasts one clock cycle. The controller never gives change. Any credit of 15 cents or more counts as the same paid state. Once paid, the release output stays high until the next synchronous reset.

Two parameters select how the controller is built, and neither changes what it does. `OUT_MODE` sets the output timing:

- **0:** the output is decoded from the state register.
- **1:** the output is combinational on the coin that completes the price.
- **2:** the combinational value is captured in a flip-flop, so the output has no decoding delay after the clock edge.

`ONE_HOT` selects between a two-bit binary state, where the state value is the credit divided by five, and a four-bit one-hot state.

Top module: `coin_release_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the credit returns to zero. After that edge `release_o` is 0 in every mode. Reset takes priority over a coin that arrives in the same cycle.
- R2: Three separate 5-cent pulses, starting from zero credit, complete the price and raise `release_o`.
- R3: A 5-cent pulse followed by a 10-cent pulse completes the price. So does a 10-cent pulse followed by a 5-cent pulse.
- R4: Two 10-cent pulses complete the price. The 5-cent overpayment lands in the same paid state.
- R5: A cycle with neither coin input high leaves the credit unchanged. Idle cycles between coins do not lose credit.
- R6: Once paid, `release_o` stays 1 on every cycle until reset, and further coins have no effect on it.
- R7: With `OUT_MODE` 0 or 2, `release_o` first reads 1 in the cycle that follows the clock edge sampling the completing coin.
- R8: With `OUT_MODE` 1, `release_o` reads 1 in the same cycle as the completing coin. It is forced to 0 in any cycle where `rst` is high.
- R9: A cycle with both coin inputs high counts as no coin, and the credit is unchanged.
- R10: The binary and one-hot encodings produce the same `release_o` on every cycle. Modes 0 and 2 also agree with each other on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| release_o | output | 1 | Chute release, high once 15 cents are paid |

## Verification
The bench drives all six builds from the same inputs. It applies the four paying orders: 5-5-5, 5-10, 10-5 and 10-10.

- The first three orders distinguish a correct credit count from one that adds the wrong amount.
- The 10-10 order shows that an overpayment is merged into the paid state.
- Idle gaps placed inside a sequence show that credit is held while no coin arrives.
- Both inputs raised together, just before a coin that would complete the price, show that a simultaneous pair adds nothing.
- Reset applied in the same cycle as a coin, or while the output is high, separates the combinational mode from the registered modes. The same-cycle rise of the combinational mode is checked against the one-cycle-later rise of the other two.

// File: rtl/coin_release_ctrl.sv
module coin_release_ctrl #(
  parameter int OUT_MODE = 0,
  parameter bit ONE_HOT  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic release_o
);
  localparam int SW = ONE_HOT ? 4 : 2;

  logic n, d;
  assign n = nickel_i & ~dime_i;
  assign d = dime_i & ~nickel_i;

  logic [SW-1:0] st_q, st_d;
  logic [1:0]    credit_lvl;
  logic          full_now, full_next, mealy_hit;

  generate
    if (ONE_HOT) begin : g_oh
      assign st_d[0] = st_q[0] & ~n & ~d;
      assign st_d[1] = (st_q[0] & n) | (st_q[1] & ~n & ~d);
      assign st_d[2] = (st_q[0] & d) | (st_q[1] & n) | (st_q[2] & ~n & ~d);
      assign st_d[3] = (st_q[1] & d) | (st_q[2] & (n | d)) | st_q[3];
      assign credit_lvl = {st_q[3] | st_q[2], st_q[3] | st_q[1]};
      assign full_now   = st_q[3];
      assign full_next  = st_d[3];
      assign mealy_hit  = st_q[3] | (st_q[2] & (n | d)) | (st_q[1] & d);
      always_ff @(posedge clk)
        if (rst) st_q <= 4'b0001;
        else     st_q <= st_d;
    end else begin : g_bin
      assign st_d[1] = st_q[1] | d | (st_q[0] & n);
      assign st_d[0] = (~st_q[0] & n) | (st_q[0] & ~n) | (st_q[1] & n) | (st_q[1] & d);
      assign credit_lvl = st_q;
      assign full_now   = st_q[1] & st_q[0];
      assign full_next  = st_d[1] & st_d[0];
      assign mealy_hit  = (st_q[1] & st_q[0]) | (st_q[1] & n) | (st_q[1] & d) | (st_q[0] & d);
      always_ff @(posedge clk)
        if (rst) st_q <= 2'b00;
        else     st_q <= st_d;
    end
  endgenerate

  generate
    if (OUT_MODE == 1) begin : g_mealy
      assign release_o = ~rst & mealy_hit;
    end else if (OUT_MODE == 2) begin : g_sreg
      logic rel_q;
      always_ff @(posedge clk)
        if (rst) rel_q <= 1'b0;
        else     rel_q <= full_next;
      assign release_o = rel_q;
    end else begin : g_moore
      assign release_o = full_now;
    end
  endgenerate
endmodule

// File: rtl/coin_release_chk.sv
module coin_release_chk #(
  parameter int OUT_MODE = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       nickel_i,
  input logic       dime_i,
  input logic       release_o,
  input logic [1:0] lvl
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (lvl == 2'd0 && !release_o));

  a_r2_nickel_step: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i && lvl != 2'd3) |=> (lvl == $past(lvl) + 2'd1));

  a_r4_dime_step: assert property (@(posedge clk) disable iff (rst)
    (dime_i && !nickel_i) |=> (lvl == (($past(lvl) == 2'd0) ? 2'd2 : 2'd3)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(lvl));

  a_r9_dual_ignored: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> $stable(lvl));

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    release_o |=> release_o);

  generate
    if (OUT_MODE == 1) begin : g_m
      a_r8_same_cycle: assert property (@(posedge clk) disable iff (rst)
        release_o |-> (lvl == 2'd3 || (lvl == 2'd2 && (nickel_i ^ dime_i)) ||
                       (lvl == 2'd1 && dime_i && !nickel_i)));
      a_r8_gated: assert property (@(posedge clk) rst |-> !release_o);
    end else begin : g_r
      a_r7_registered: assert property (@(posedge clk) disable iff (rst)
        release_o == (lvl == 2'd3));
    end
  endgenerate
endmodule

bind coin_release_ctrl coin_release_chk #(.OUT_MODE(OUT_MODE)) u_chk (
  .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i),
  .release_o(release_o), .lvl(credit_lvl)
);

// File: tb/tb_coin_release_ctrl.sv
module tb_coin_release_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic [5:0] rel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  coin_release_ctrl #(.OUT_MODE(0), .ONE_HOT(1'b0)) dut (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[0]));
  coin_release_ctrl #(.OUT_MODE(0), .ONE_HOT(1'b1)) dut_moore_oh (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[1]));
  coin_release_ctrl #(.OUT_MODE(1), .ONE_HOT(1'b0)) dut_mealy_bin (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[2]));
  coin_release_ctrl #(.OUT_MODE(1), .ONE_HOT(1'b1)) dut_mealy_oh (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[3]));
  coin_release_ctrl #(.OUT_MODE(2), .ONE_HOT(1'b0)) dut_sreg_bin (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[4]));
  coin_release_ctrl #(.OUT_MODE(2), .ONE_HOT(1'b1)) dut_sreg_oh (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[5]));

  // {tag[3:0], rst, nickel, dime, expect registered/decoded, expect combinational}
  localparam int NV = 36;
  localparam logic [8:0] VEC [NV] = '{
    {4'd2, 5'b01000}, {4'd5, 5'b00000}, {4'd2, 5'b01000}, {4'd8, 5'b01001},
    {4'd7, 5'b00011}, {4'd6, 5'b00011}, {4'd1, 5'b10010},
    {4'd3, 5'b01000}, {4'd8, 5'b00101}, {4'd7, 5'b00011}, {4'd1, 5'b10010},
    {4'd3, 5'b00100}, {4'd8, 5'b01001}, {4'd7, 5'b00011}, {4'd1, 5'b10010},
    {4'd4, 5'b00100}, {4'd5, 5'b00000}, {4'd8, 5'b00101}, {4'd6, 5'b01011},
    {4'd1, 5'b10010},
    {4'd9, 5'b01100}, {4'd2, 5'b01000}, {4'd9, 5'b01100}, {4'd9, 5'b01100},
    {4'd8, 5'b00101}, {4'd7, 5'b00011}, {4'd1, 5'b10110}, {4'd1, 5'b00000},
    {4'd2, 5'b01000}, {4'd1, 5'b11000},
    {4'd2, 5'b01000}, {4'd2, 5'b01000}, {4'd5, 5'b00000}, {4'd8, 5'b01001},
    {4'd7, 5'b00011}, {4'd1, 5'b10010}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_all(input logic er, input logic em, input string req);
    check(rel[0], er, req, "moore binary");
    check(rel[1], er, req, "moore one-hot");
    check(rel[2], em, req, "mealy binary");
    check(rel[3], em, req, "mealy one-hot");
    check(rel[4], er, req, "registered mealy binary");
    check(rel[5], er, req, "registered mealy one-hot");
    // R10: encodings and the two registered styles agree
    check(rel[1], rel[0], "R10", "one-hot vs binary (decoded)");
    check(rel[3], rel[2], "R10", "one-hot vs binary (combinational)");
    check(rel[4], rel[0], "R10", "registered vs decoded");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 check_all(1'b0, 1'b0, "R1");
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst    = VEC[i][4];
      nickel = VEC[i][3];
      dime   = VEC[i][2];
      #1 check_all(VEC[i][1], VEC[i][0], tag_name(VEC[i][8:5]));
    end
    // R5: long idle stretch after reset keeps everything closed
    @(negedge clk);
    rst = 1'b0; nickel = 1'b0; dime = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      #1 check_all(1'b0, 1'b0, "R5");
    end
    // R9: dual pulses only never pay
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      nickel = 1'b1; dime = 1'b1;
      #1 check_all(1'b0, 1'b0, "R9");
    end
    @(negedge clk);
    nickel = 1'b0; dime = 1'b0;
    #1 check_all(1'b0, 1'b0, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule